// File: doc/BRIEF.md
# Target Debug Operation Sequencer

This block turns one high-level debug request into the ordered stream of commands that a serial test-port shift engine needs to halt a target processor, let it run again, read or write one memory location, load its program counter, or put it through a power-on reset. Each request carries an operation code, a 16-bit address and 16-bit data. The sequencer then walks a fixed list of steps. A step is an 8-bit instruction-register shift, a 16-bit data-register shift, or a drive of the target clock (TCLK) low or high. At the end it raises a one-cycle completion pulse together with a 16-bit result.

Requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low for the whole operation, so the requester has to hold its request until it is accepted. Commands to the shift engine also use valid/ready. A command is stable while it waits for `eng_cmd_ready`. After a command is accepted, no new command is issued until the engine reports that the command has finished with `eng_done`. The engine may therefore stall either phase for any number of cycles.

The sequencer selects the access control word from the address range: byte access at 0x00FF and below, word access above. It also places every TCLK edge at its exact position between register shifts.

Top module: `dbg_seq`

## Requirements
- R1: After reset, `busy`, `done` and `eng_cmd_valid` are 0, `req_ready` is 1 and `rdata` is 0x0000.
- R2: A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. From the next cycle until completion, `busy` is 1 and `req_ready` is 0, and any `req_valid` in that time is ignored. Each operation ends with `done` high for exactly one cycle, and `busy` falls on that same edge.
- R3: Engine command kinds are encoded as IR shift = 0 (opcode in bits 7:0 of `eng_cmd_data`), DR shift = 1, TCLK low = 2 and TCLK high = 3. A command holds kind and data until accepted, and the next command waits for `eng_done`. The default instruction opcodes are control 0x13, data 0x41, address 0x83, address-capture 0x84 and data-to-address 0x85.
- R4: Halt (op 0) issues IR data, DR 0x3FFF, TCLK low, IR control, DR 0x2409, TCLK high.
- R5: Release (op 1) issues TCLK low, IR control, DR 0x2401, IR address-capture, TCLK high.
- R6: Read (op 2) first runs the complete halt sequence. It then issues TCLK low, IR control, and DR 0x2409 if the address is above 0x00FF or DR 0x2419 otherwise. Next come IR address, DR address, IR data-to-address, TCLK high, TCLK low and DR 0x0000. `rdata` is the value returned by that last shift.
- R7: Write (op 3) issues TCLK low, IR control, and DR 0x2408 if the address is above 0x00FF or DR 0x2418 otherwise. It then issues IR address, DR address, IR data-to-address, DR data and TCLK high.
- R8: Set-PC (op 4, value on `req_wdata`) issues IR control, DR 0x3401, IR data, DR 0x4030, TCLK low, TCLK high, DR value, TCLK low, IR address-capture, TCLK high, TCLK low, IR control, DR 0x2401.
- R9: Power-on reset (op 5) issues IR control, DR 0x2C01, DR 0x2401, TCLK low/high/low/high/low, IR address-capture, TCLK high, then the write sequence of R7 for data 0x5A80 at address 0x0120. `rdata` is the low byte returned by the address-capture shift, zero-extended.
- R10: Reserved op codes 6 and 7 issue no engine command and complete with `done` and `rdata` 0x0000.
- R11: Halt, release, write and set-PC report `rdata` 0x0000, even when an earlier read left a different value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_op | input | 3 | Operation code |
| req_addr | input | 16 | Target address |
| req_wdata | input | 16 | Write data or program counter value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Result, valid from the done pulse |
| eng_cmd_valid | output | 1 | Command to the shift engine present |
| eng_cmd_ready | input | 1 | Engine takes the command |
| eng_cmd_kind | output | 2 | Command kind (R3) |
| eng_cmd_data | output | 16 | Shift value or opcode |
| eng_done | input | 1 | Accepted command finished |
| eng_rdata | input | 16 | Value shifted out by the finished command |

## Verification
Every operation runs against a behavioural engine model that logs each accepted command. The log must match the full expected list, which tells apart a swapped step, a missing step and a wrong TCLK position. Reads and writes go to 0x00FF, 0x0100 and addresses well away from the boundary, which separates the byte and word control words at the limit. The engine model runs with zero latency and again with long ready and done delays, so a command that is issued twice or not held shows up in the log. The model returns different values for IR and DR shifts, which shows whether the result comes from the correct shift, is truncated to the correct width, and is cleared for operations that capture nothing.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;

  localparam int DW   = 16;
  localparam int OPW  = 3;
  localparam int IDXW = 5;

  typedef enum logic [2:0] {
    K_IR  = 3'd0,
    K_DR  = 3'd1,
    K_TLO = 3'd2,
    K_THI = 3'd3,
    K_NOP = 3'd4
  } step_kind_e;

  typedef struct packed {
    step_kind_e    kind;
    logic [DW-1:0] data;
    logic          cap;
    logic          last;
  } step_t;

  localparam logic [OPW-1:0] OP_HALT    = 3'd0;
  localparam logic [OPW-1:0] OP_RELEASE = 3'd1;
  localparam logic [OPW-1:0] OP_READ    = 3'd2;
  localparam logic [OPW-1:0] OP_WRITE   = 3'd3;
  localparam logic [OPW-1:0] OP_SETPC   = 3'd4;
  localparam logic [OPW-1:0] OP_POR     = 3'd5;

  // step counts per operation
  localparam logic [IDXW-1:0] N_HALT    = 5'd6;
  localparam logic [IDXW-1:0] N_RELEASE = 5'd5;
  localparam logic [IDXW-1:0] N_RDTAIL  = 5'd9;
  localparam logic [IDXW-1:0] N_WRITE   = 5'd8;
  localparam logic [IDXW-1:0] N_SETPC   = 5'd13;
  localparam logic [IDXW-1:0] N_PORHEAD = 5'd10;

  // control-signal words
  localparam logic [DW-1:0] CW_RUN      = 16'h2401;
  localparam logic [DW-1:0] CW_RD_WORD  = 16'h2409;
  localparam logic [DW-1:0] CW_RD_BYTE  = 16'h2419;
  localparam logic [DW-1:0] CW_WR_WORD  = 16'h2408;
  localparam logic [DW-1:0] CW_WR_BYTE  = 16'h2418;
  localparam logic [DW-1:0] CW_PC_LOAD  = 16'h3401;
  localparam logic [DW-1:0] CW_RESET    = 16'h2C01;
  localparam logic [DW-1:0] DV_SELFJMP  = 16'h3FFF;
  localparam logic [DW-1:0] DV_MOVPC    = 16'h4030;
  localparam logic [DW-1:0] WDOG_ADDR   = 16'h0120;
  localparam logic [DW-1:0] WDOG_HOLD   = 16'h5A80;

  function automatic step_t mk(step_kind_e k, logic [DW-1:0] d, logic c);
    step_t s;
    s.kind = k;
    s.data = d;
    s.cap  = c;
    s.last = 1'b0;
    return s;
  endfunction

endpackage

// File: rtl/dbg_seq_steps.sv
module dbg_seq_steps
  import dbg_seq_pkg::*;
#(
  parameter logic [7:0]    OPC_CTRL  = 8'h13,
  parameter logic [7:0]    OPC_DATA  = 8'h41,
  parameter logic [7:0]    OPC_ADDR  = 8'h83,
  parameter logic [7:0]    OPC_ACAP  = 8'h84,
  parameter logic [7:0]    OPC_D2A   = 8'h85,
  parameter logic [DW-1:0] BYTE_LIM  = 16'h00FF
) (
  input  logic [OPW-1:0]  op,
  input  logic [IDXW-1:0] idx,
  input  logic [DW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output step_t           step
);

  localparam logic [DW-1:0] I_CTRL = {{(DW-8){1'b0}}, OPC_CTRL};
  localparam logic [DW-1:0] I_DATA = {{(DW-8){1'b0}}, OPC_DATA};
  localparam logic [DW-1:0] I_ADDR = {{(DW-8){1'b0}}, OPC_ADDR};
  localparam logic [DW-1:0] I_ACAP = {{(DW-8){1'b0}}, OPC_ACAP};
  localparam logic [DW-1:0] I_D2A  = {{(DW-8){1'b0}}, OPC_D2A};
  localparam logic [DW-1:0] ZERO   = '0;

  function automatic step_t halt_step(logic [IDXW-1:0] i);
    case (i)
      5'd0:    return mk(K_IR,  I_DATA, 1'b0);
      5'd1:    return mk(K_DR,  DV_SELFJMP, 1'b0);
      5'd2:    return mk(K_TLO, ZERO, 1'b0);
      5'd3:    return mk(K_IR,  I_CTRL, 1'b0);
      5'd4:    return mk(K_DR,  CW_RD_WORD, 1'b0);
      default: return mk(K_THI, ZERO, 1'b0);
    endcase
  endfunction

  function automatic step_t release_step(logic [IDXW-1:0] i);
    case (i)
      5'd0:    return mk(K_TLO, ZERO, 1'b0);
      5'd1:    return mk(K_IR,  I_CTRL, 1'b0);
      5'd2:    return mk(K_DR,  CW_RUN, 1'b0);
      5'd3:    return mk(K_IR,  I_ACAP, 1'b0);
      default: return mk(K_THI, ZERO, 1'b0);
    endcase
  endfunction

  function automatic step_t read_step(logic [IDXW-1:0] i, logic [DW-1:0] a);
    case (i)
      5'd0:    return mk(K_TLO, ZERO, 1'b0);
      5'd1:    return mk(K_IR,  I_CTRL, 1'b0);
      5'd2:    return mk(K_DR,  (a > BYTE_LIM) ? CW_RD_WORD : CW_RD_BYTE, 1'b0);
      5'd3:    return mk(K_IR,  I_ADDR, 1'b0);
      5'd4:    return mk(K_DR,  a, 1'b0);
      5'd5:    return mk(K_IR,  I_D2A, 1'b0);
      5'd6:    return mk(K_THI, ZERO, 1'b0);
      5'd7:    return mk(K_TLO, ZERO, 1'b0);
      default: return mk(K_DR,  ZERO, 1'b1);
    endcase
  endfunction

  function automatic step_t write_step(logic [IDXW-1:0] i, logic [DW-1:0] a,
                                       logic [DW-1:0] d);
    case (i)
      5'd0:    return mk(K_TLO, ZERO, 1'b0);
      5'd1:    return mk(K_IR,  I_CTRL, 1'b0);
      5'd2:    return mk(K_DR,  (a > BYTE_LIM) ? CW_WR_WORD : CW_WR_BYTE, 1'b0);
      5'd3:    return mk(K_IR,  I_ADDR, 1'b0);
      5'd4:    return mk(K_DR,  a, 1'b0);
      5'd5:    return mk(K_IR,  I_D2A, 1'b0);
      5'd6:    return mk(K_DR,  d, 1'b0);
      default: return mk(K_THI, ZERO, 1'b0);
    endcase
  endfunction

  function automatic step_t setpc_step(logic [IDXW-1:0] i, logic [DW-1:0] v);
    case (i)
      5'd0:    return mk(K_IR,  I_CTRL, 1'b0);
      5'd1:    return mk(K_DR,  CW_PC_LOAD, 1'b0);
      5'd2:    return mk(K_IR,  I_DATA, 1'b0);
      5'd3:    return mk(K_DR,  DV_MOVPC, 1'b0);
      5'd4:    return mk(K_TLO, ZERO, 1'b0);
      5'd5:    return mk(K_THI, ZERO, 1'b0);
      5'd6:    return mk(K_DR,  v, 1'b0);
      5'd7:    return mk(K_TLO, ZERO, 1'b0);
      5'd8:    return mk(K_IR,  I_ACAP, 1'b0);
      5'd9:    return mk(K_THI, ZERO, 1'b0);
      5'd10:   return mk(K_TLO, ZERO, 1'b0);
      5'd11:   return mk(K_IR,  I_CTRL, 1'b0);
      default: return mk(K_DR,  CW_RUN, 1'b0);
    endcase
  endfunction

  function automatic step_t por_step(logic [IDXW-1:0] i);
    case (i)
      5'd0:    return mk(K_IR,  I_CTRL, 1'b0);
      5'd1:    return mk(K_DR,  CW_RESET, 1'b0);
      5'd2:    return mk(K_DR,  CW_RUN, 1'b0);
      5'd3, 5'd5, 5'd7:
               return mk(K_TLO, ZERO, 1'b0);
      5'd4, 5'd6:
               return mk(K_THI, ZERO, 1'b0);
      5'd8:    return mk(K_IR,  I_ACAP, 1'b1);
      default: return mk(K_THI, ZERO, 1'b0);
    endcase
  endfunction

  logic [IDXW-1:0] len;

  always_comb begin
    step = mk(K_NOP, ZERO, 1'b0);
    len  = 5'd1;
    case (op)
      OP_HALT: begin
        step = halt_step(idx);
        len  = N_HALT;
      end
      OP_RELEASE: begin
        step = release_step(idx);
        len  = N_RELEASE;
      end
      OP_READ: begin
        step = (idx < N_HALT) ? halt_step(idx) : read_step(idx - N_HALT, addr);
        len  = N_HALT + N_RDTAIL;
      end
      OP_WRITE: begin
        step = write_step(idx, addr, wdata);
        len  = N_WRITE;
      end
      OP_SETPC: begin
        step = setpc_step(idx, wdata);
        len  = N_SETPC;
      end
      OP_POR: begin
        step = (idx < N_PORHEAD) ? por_step(idx)
                                 : write_step(idx - N_PORHEAD, WDOG_ADDR, WDOG_HOLD);
        len  = N_PORHEAD + N_WRITE;
      end
      default: begin
        step = mk(K_NOP, ZERO, 1'b0);
        len  = 5'd1;
      end
    endcase
    step.last = (idx == len - 5'd1);
  end

endmodule

// File: rtl/dbg_seq_issue.sv
module dbg_seq_issue
  import dbg_seq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [1:0]    kind,
  input  logic [DW-1:0] data,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [1:0]    cmd_kind,
  output logic [DW-1:0] cmd_data,
  input  logic          eng_done,
  input  logic [DW-1:0] eng_rdata,
  output logic          ack,
  output logic [DW-1:0] ack_data
);

  logic in_flight;

  assign cmd_valid = go && !in_flight;
  assign cmd_kind  = kind;
  assign cmd_data  = data;
  assign ack       = in_flight && eng_done;
  assign ack_data  = eng_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_flight <= 1'b0;
    end else if (cmd_valid && cmd_ready) begin
      in_flight <= 1'b1;
    end else if (ack) begin
      in_flight <= 1'b0;
    end
  end

endmodule

// File: rtl/dbg_seq_ctrl.sv
module dbg_seq_ctrl
  import dbg_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [OPW-1:0]  req_op,
  input  logic [DW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic            req_ready,
  output logic            busy,
  output logic            done,
  output logic [DW-1:0]   rdata,
  input  step_t           step,
  input  logic            ack,
  input  logic [DW-1:0]   ack_data,
  output logic [OPW-1:0]  op_q,
  output logic [DW-1:0]   addr_q,
  output logic [DW-1:0]   wdata_q,
  output logic [IDXW-1:0] idx,
  output logic            go
);

  logic [DW-1:0] cap_q, cap_next;
  logic          is_nop;

  assign is_nop    = (step.kind == K_NOP);
  assign req_ready = !busy;
  assign go        = busy && !is_nop;

  always_comb begin
    cap_next = cap_q;
    if (ack && step.cap) begin
      cap_next = (step.kind == K_IR) ? {{(DW-8){1'b0}}, ack_data[7:0]} : ack_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      rdata   <= '0;
      cap_q   <= '0;
      op_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      idx     <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          busy    <= 1'b1;
          op_q    <= req_op;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          idx     <= '0;
          cap_q   <= '0;
        end
      end else if (is_nop) begin
        busy  <= 1'b0;
        done  <= 1'b1;
        rdata <= cap_q;
      end else if (ack) begin
        cap_q <= cap_next;
        if (step.last) begin
          busy  <= 1'b0;
          done  <= 1'b1;
          rdata <= cap_next;
        end else begin
          idx <= idx + 5'd1;
        end
      end
    end
  end

endmodule

// File: rtl/dbg_seq.sv
module dbg_seq
  import dbg_seq_pkg::*;
#(
  parameter logic [7:0]  OPC_CTRL = 8'h13,
  parameter logic [7:0]  OPC_DATA = 8'h41,
  parameter logic [7:0]  OPC_ADDR = 8'h83,
  parameter logic [7:0]  OPC_ACAP = 8'h84,
  parameter logic [7:0]  OPC_D2A  = 8'h85,
  parameter logic [15:0] BYTE_LIM = 16'h00FF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [2:0]  req_op,
  input  logic [15:0] req_addr,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdata,
  output logic        eng_cmd_valid,
  input  logic        eng_cmd_ready,
  output logic [1:0]  eng_cmd_kind,
  output logic [15:0] eng_cmd_data,
  input  logic        eng_done,
  input  logic [15:0] eng_rdata
);

  step_t           step;
  logic            ack, go;
  logic [DW-1:0]   ack_data, addr_q, wdata_q;
  logic [OPW-1:0]  op_q;
  logic [IDXW-1:0] idx;

  dbg_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_ready (req_ready),
    .busy      (busy),
    .done      (done),
    .rdata     (rdata),
    .step      (step),
    .ack       (ack),
    .ack_data  (ack_data),
    .op_q      (op_q),
    .addr_q    (addr_q),
    .wdata_q   (wdata_q),
    .idx       (idx),
    .go        (go)
  );

  dbg_seq_steps #(
    .OPC_CTRL (OPC_CTRL),
    .OPC_DATA (OPC_DATA),
    .OPC_ADDR (OPC_ADDR),
    .OPC_ACAP (OPC_ACAP),
    .OPC_D2A  (OPC_D2A),
    .BYTE_LIM (BYTE_LIM)
  ) u_steps (
    .op    (op_q),
    .idx   (idx),
    .addr  (addr_q),
    .wdata (wdata_q),
    .step  (step)
  );

  dbg_seq_issue u_issue (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .kind      (step.kind[1:0]),
    .data      (step.data),
    .cmd_valid (eng_cmd_valid),
    .cmd_ready (eng_cmd_ready),
    .cmd_kind  (eng_cmd_kind),
    .cmd_data  (eng_cmd_data),
    .eng_done  (eng_done),
    .eng_rdata (eng_rdata),
    .ack       (ack),
    .ack_data  (ack_data)
  );

endmodule

// File: rtl/dbg_seq_chk.sv
module dbg_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        busy,
  input logic        done,
  input logic        eng_cmd_valid,
  input logic        eng_cmd_ready,
  input logic [1:0]  eng_cmd_kind,
  input logic [15:0] eng_cmd_data
);

  assert_cmd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cmd_valid && !eng_cmd_ready |=>
      eng_cmd_valid && $stable(eng_cmd_kind) && $stable(eng_cmd_data));

  assert_one_in_flight_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cmd_valid && eng_cmd_ready |=> !eng_cmd_valid);

  assert_cmd_in_op_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cmd_valid |-> busy);

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !eng_cmd_valid && $past(busy));

  assert_start_on_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

endmodule

bind dbg_seq dbg_seq_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .busy          (busy),
  .done          (done),
  .eng_cmd_valid (eng_cmd_valid),
  .eng_cmd_ready (eng_cmd_ready),
  .eng_cmd_kind  (eng_cmd_kind),
  .eng_cmd_data  (eng_cmd_data)
);

// File: tb/dbg_seq_bench.sv
`timescale 1ns/1ps
module dbg_seq_bench;

  localparam logic [15:0] I_CTRL = 16'h0013, I_DATA = 16'h0041, I_ADDR = 16'h0083;
  localparam logic [15:0] I_ACAP = 16'h0084, I_D2A  = 16'h0085;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [2:0] req_op = '0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic busy, done;
  logic [15:0] rdata;
  logic eng_cmd_valid, eng_cmd_ready = 1'b0;
  logic [1:0] eng_cmd_kind;
  logic [15:0] eng_cmd_data;
  logic eng_done = 1'b0;
  logic [15:0] eng_rdata = '0;

  always #10 clk = ~clk;

  dbg_seq u_dbg_seq (.*);

  int checks = 0, errors = 0;
  int rdy_dly = 0, lat = 0;
  logic [15:0] resp_ir = 16'h0000, resp_dr = 16'h0000;
  logic [17:0] log_q [32];
  logic [17:0] exp_q [32];
  int log_n = 0, exp_n = 0;
  logic [15:0] got_rdata;

  // engine model: logs each accepted command, answers with eng_done
  initial begin
    forever begin
      @(negedge clk);
      if (eng_cmd_valid) begin
        repeat (rdy_dly) @(negedge clk);
        if (log_n < 32) log_q[log_n] = {eng_cmd_kind, eng_cmd_data};
        log_n++;
        eng_cmd_ready = 1'b1;
        @(negedge clk);
        eng_cmd_ready = 1'b0;
        repeat (lat) @(negedge clk);
        eng_rdata = (eng_cmd_kind == 2'd0) ? resp_ir :
                    (eng_cmd_kind == 2'd1) ? resp_dr : 16'h0000;
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] k, input logic [15:0] d);
    exp_q[exp_n] = {k, d};
    exp_n++;
  endtask
  task automatic e_ir(input logic [15:0] v); push(2'd0, v); endtask
  task automatic e_dr(input logic [15:0] v); push(2'd1, v); endtask
  task automatic e_lo(); push(2'd2, 16'h0); endtask
  task automatic e_hi(); push(2'd3, 16'h0); endtask

  task automatic e_halt();
    e_ir(I_DATA); e_dr(16'h3FFF); e_lo(); e_ir(I_CTRL); e_dr(16'h2409); e_hi();
  endtask
  task automatic e_write(input logic [15:0] a, input logic [15:0] d);
    e_lo(); e_ir(I_CTRL); e_dr(a > 16'h00FF ? 16'h2408 : 16'h2418);
    e_ir(I_ADDR); e_dr(a); e_ir(I_D2A); e_dr(d); e_hi();
  endtask

  task automatic cmp_seq(input string req);
    int bad = -1;
    for (int i = 0; i < exp_n && i < 32; i++)
      if (bad < 0 && (i >= log_n || log_q[i] !== exp_q[i])) bad = i;
    if (log_n != exp_n) check(1'b0, {req, " command count"}, log_n, exp_n);
    else if (bad >= 0) check(1'b0, {req, " command"}, {14'h0, log_q[bad]}, {14'h0, exp_q[bad]});
    else check(1'b1, req, 0, 0);
  endtask

  // issue one request, wait for completion, check R2 handshake
  task automatic run_op(input logic [2:0] op, input logic [15:0] a, input logic [15:0] d);
    int n = 0;
    bit ready_bad = 0;
    log_n = 0;
    @(negedge clk);
    req_op = op; req_addr = a; req_wdata = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy === 1'b1, "R2 busy after accept", busy, 1);
    while (done !== 1'b1 && n < 5000) begin
      if (busy && req_ready) ready_bad = 1;
      @(negedge clk);
      n++;
    end
    check(!ready_bad, "R2 req_ready low while busy", ready_bad, 0);
    check(done === 1'b1 && busy === 1'b0, "R2 done with busy low", {busy, done}, 2'b01);
    got_rdata = rdata;
    @(negedge clk);
    check(done === 1'b0, "R2 done one cycle", done, 0);
  endtask

  task automatic t_reset();
    check(busy === 0 && done === 0 && eng_cmd_valid === 0 && req_ready === 1,
          "R1 reset outputs", {busy, done, eng_cmd_valid, req_ready}, 4'b0001);
    check(rdata === 16'h0, "R1 reset rdata", rdata, 0);
  endtask

  task automatic t_halt();
    exp_n = 0; e_halt();
    run_op(3'd0, 16'h0, 16'h0);
    cmp_seq("R4 halt");
    check(got_rdata === 16'h0, "R11 halt rdata", got_rdata, 0);
  endtask

  task automatic t_release();
    exp_n = 0; e_lo(); e_ir(I_CTRL); e_dr(16'h2401); e_ir(I_ACAP); e_hi();
    run_op(3'd1, 16'h0, 16'h0);
    cmp_seq("R5 release");
  endtask

  task automatic t_read(input logic [15:0] a, input logic [15:0] v);
    resp_dr = v;
    exp_n = 0; e_halt();
    e_lo(); e_ir(I_CTRL); e_dr(a > 16'h00FF ? 16'h2409 : 16'h2419);
    e_ir(I_ADDR); e_dr(a); e_ir(I_D2A); e_hi(); e_lo(); e_dr(16'h0000);
    run_op(3'd2, a, 16'h1111);
    cmp_seq("R6 read");
    check(got_rdata === v, "R6 read data", got_rdata, v);
  endtask

  task automatic t_write(input logic [15:0] a, input logic [15:0] d);
    exp_n = 0; e_write(a, d);
    run_op(3'd3, a, d);
    cmp_seq("R7 write");
    check(got_rdata === 16'h0, "R11 write rdata", got_rdata, 0);
  endtask

  task automatic t_setpc(input logic [15:0] v);
    exp_n = 0;
    e_ir(I_CTRL); e_dr(16'h3401); e_ir(I_DATA); e_dr(16'h4030); e_lo(); e_hi();
    e_dr(v); e_lo(); e_ir(I_ACAP); e_hi(); e_lo(); e_ir(I_CTRL); e_dr(16'h2401);
    run_op(3'd4, 16'h0, v);
    cmp_seq("R8 setpc");
    check(got_rdata === 16'h0, "R11 setpc rdata", got_rdata, 0);
  endtask

  task automatic t_por();
    resp_ir = 16'hFF89;
    exp_n = 0;
    e_ir(I_CTRL); e_dr(16'h2C01); e_dr(16'h2401);
    e_lo(); e_hi(); e_lo(); e_hi(); e_lo(); e_ir(I_ACAP); e_hi();
    e_write(16'h0120, 16'h5A80);
    run_op(3'd5, 16'hAAAA, 16'h5555);
    cmp_seq("R9 por");
    check(got_rdata === 16'h0089, "R9 por id", got_rdata, 16'h0089);
  endtask

  task automatic t_reserved(input logic [2:0] op);
    run_op(op, 16'h1234, 16'h5678);
    check(log_n == 0, "R10 reserved no commands", log_n, 0);
    check(got_rdata === 16'h0, "R10 reserved rdata", got_rdata, 0);
  endtask

  task automatic t_busy_ignore();
    bit busy_seen = 0;
    lat = 3;
    exp_n = 0; e_halt();
    log_n = 0;
    @(negedge clk);
    req_op = 3'd0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    req_op = 3'd3; req_addr = 16'h0300; req_wdata = 16'hDEAD; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 400 && done !== 1'b1; i++) @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (busy) busy_seen = 1;
    end
    check(!busy_seen, "R2 request during busy ignored", busy_seen, 0);
    cmp_seq("R2 only first request ran");
    lat = 0;
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_halt();
    t_release();
    t_read(16'h1234, 16'hBEEF);
    t_read(16'h00FF, 16'h00A7);
    t_read(16'h0100, 16'h3C3C);
    t_halt();
    t_write(16'h0200, 16'hCAFE);
    t_write(16'h0010, 16'h00AB);
    t_write(16'h00FF, 16'h0001);
    t_write(16'h0100, 16'h0002);
    t_setpc(16'hF800);
    t_por();
    t_reserved(3'd6);
    t_reserved(3'd7);
    rdy_dly = 3; lat = 2;
    t_write(16'h4000, 16'h1357);
    t_read(16'h0050, 16'h0042);
    t_setpc(16'hE00A);
    rdy_dly = 0; lat = 0;
    t_busy_ignore();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule